// File: doc/BRIEF.md
# Half-Duplex Synchronous Serial Shifter

This block is a master for a simple synchronous serial link. The host presents a 16-bit data word, a 16-bit transfer length, a half-period divisor and two mode bits, and then pulses `start`. The block produces a serial clock and moves the data word out through `sdo`, least significant bit first. In the same transfer it shifts the bits sampled on `sdi` into that same register from the top end. When the last clock pulse has finished, it raises `done`.

The received bits are never realigned. For a short transfer, the bits still waiting to go out sit in the low end of `rx_word` and the bits that came in sit in the high end. A transfer length above 16 is legal and keeps clocking, which lets the host capture only the tail of a longer incoming stream. In clock-only mode the block produces clock pulses without touching the data, and it can produce up to 65535 of them.

Top module: `sync_shift_master`

## Requirements
- R1: A `start` pulse while idle loads `tx_word` into the data register and latches the mode bits, the divisor and the length. It then produces exactly `xfer_len` clock pulses. A length of 0 produces no clock pulse, sets `done` on the next cycle and leaves `rx_word` equal to `tx_word`.
- R2: Every clock level lasts exactly `half_div` cycles, using the value latched at start. A divisor of 0 behaves as 1.
- R3: `sdo` presents register bit 0 before each leading clock edge and changes only while the clock is at its idle level. Bits leave in order from the least significant bit upward.
- R4: `sdi` is sampled on each leading clock edge. It enters bit 15 as the register shifts right on the following trailing edge. After N < 16 bits, `rx_word` = {received bits, `tx_word[15:N]`}, with the first received bit at position 16-N.
- R5: A 16-bit transfer replaces the whole register with the received bits, and the first received bit ends up at bit 0.
- R6: A length above 16 keeps clocking and shifting for all pulses, so `rx_word` ends holding the last 16 received bits.
- R7: With `clk_only` = 1, the block produces `xfer_len` pulses (up to 65535), `sdo` stays 0 and `rx_word` keeps the loaded `tx_word`.
- R8: The clock rests at the idle level given by `idle_high` (latched at start) whenever the block is not busy. The leading edge is the move away from that level.
- R9: A `start` pulse while busy is ignored. The data, mode bits and result of the transfer in progress are unchanged.
- R10: `done` rises in the cycle after the final trailing edge and stays high until the next accepted `start`. `done` and `busy` are never high together. `rx_word` holds still while the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a transfer |
| tx_word | input | 16 | Data word loaded at start |
| xfer_len | input | 16 | Number of clock pulses / bits |
| half_div | input | 16 | Cycles per clock level (0 treated as 1) |
| clk_only | input | 1 | 1 = produce clocks only, move no data |
| idle_high | input | 1 | Idle level of the serial clock |
| sdi | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer finished |
| rx_word | output | 16 | Data register contents |

## Verification
The assertions check the following on every cycle:
- `done` and `busy` are never high together.
- The clock sits at its latched idle level whenever the block is idle.
- `sdo` changes only while the clock is at its idle level, and stays 0 in clock-only mode.
- `rx_word` is frozen between transfers, and `done` holds until a new start.

The bench scenarios are needed for the rest:
- the exact count of clock pulses and the length of each clock level, including a divisor of 0;
- the order of the bits sent;
- where the received bits land for short, full and over-long transfers;
- the 65535-pulse clock-only burst;
- the proof that a start pulse during a transfer leaves its result untouched.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    // Phase of the serial clock while a transfer runs.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // no transfer, clock at idle level
        PH_REST  = 2'd1,   // clock at idle level, output bit driven
        PH_PULSE = 2'd2    // clock away from idle level, input bit captured
    } phase_e;

endpackage

// File: rtl/ssm_half_timer.sv
module ssm_half_timer #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] period;
        logic [DIV_W-1:0] left;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d    = q;
        tick = 1'b0;
        if (load) begin
            d.period = (div == '0) ? ONE : div;
            d.left   = d.period;
        end else if (run) begin
            if (q.left == ONE) begin
                tick   = 1'b1;
                d.left = q.period;
            end else begin
                d.left = q.left - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.period <= ONE;
            q.left   <= ONE;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/ssm_shifter.sv
module ssm_shifter #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              capture,
    input  logic              shift,
    input  logic              sin,
    output logic [DATA_W-1:0] word,
    output logic              lsb
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              held;
    } shr_t;

    shr_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.word = load_val;
        end else begin
            if (capture) d.held = sin;
            if (shift)   d.word = {q.held, q.word[DATA_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.word <= '0;
            q.held <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign word = q.word;
    assign lsb  = q.word[0];

endmodule

// File: rtl/ssm_sequencer.sv
module ssm_sequencer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    input  logic             clk_only,
    input  logic             idle_high,
    input  logic             tick,
    output logic             load,
    output logic             capture,
    output logic             shift,
    output logic             busy,
    output logic             done,
    output logic             sclk,
    output logic             data_en,
    output logic             pol,
    output logic             conly
);

    import ssm_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] remaining;
        logic             pol;
        logic             conly;
        logic             done;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d       = q;
        load    = 1'b0;
        capture = 1'b0;
        shift   = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    d.pol   = idle_high;
                    d.conly = clk_only;
                    if (len == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.done      = 1'b0;
                        d.remaining = len;
                        d.phase     = PH_REST;
                    end
                end
            end
            PH_REST: begin
                if (tick) begin
                    capture = !q.conly;
                    d.phase = PH_PULSE;
                end
            end
            PH_PULSE: begin
                if (tick) begin
                    shift = !q.conly;
                    if (q.remaining == ONE) begin
                        d.phase = PH_IDLE;
                        d.done  = 1'b1;
                    end else begin
                        d.remaining = q.remaining - ONE;
                        d.phase     = PH_REST;
                    end
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase     <= PH_IDLE;
            q.remaining <= '0;
            q.pol       <= 1'b0;
            q.conly     <= 1'b0;
            q.done      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.phase != PH_IDLE);
    assign done    = q.done;
    assign sclk    = q.pol ^ (q.phase == PH_PULSE);
    assign data_en = busy && !q.conly;
    assign pol     = q.pol;
    assign conly   = q.conly;

endmodule

// File: rtl/sync_shift_master.sv
module sync_shift_master #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [CNT_W-1:0]  xfer_len,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              clk_only,
    input  logic              idle_high,
    input  logic              sdi,
    output logic              sclk,
    output logic              sdo,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);

    logic tick, seq_load, seq_capture, seq_shift, seq_data_en;
    logic seq_pol, seq_conly, reg_lsb;

    ssm_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .len       (xfer_len),
        .clk_only  (clk_only),
        .idle_high (idle_high),
        .tick      (tick),
        .load      (seq_load),
        .capture   (seq_capture),
        .shift     (seq_shift),
        .busy      (busy),
        .done      (done),
        .sclk      (sclk),
        .data_en   (seq_data_en),
        .pol       (seq_pol),
        .conly     (seq_conly)
    );

    ssm_half_timer #(.DIV_W(DIV_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (seq_load),
        .run   (busy),
        .div   (half_div),
        .tick  (tick)
    );

    ssm_shifter #(.DATA_W(DATA_W)) u_shr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seq_load),
        .load_val (tx_word),
        .capture  (seq_capture),
        .shift    (seq_shift),
        .sin      (sdi),
        .word     (rx_word),
        .lsb      (reg_lsb)
    );

    assign sdo = seq_data_en & reg_lsb;

endmodule

// File: rtl/ssm_checker.sv
module ssm_checker #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              sclk,
    input logic              sdo,
    input logic              pol_lvl,
    input logic              conly_lvl,
    input logic [DATA_W-1:0] rx_word
);

    // R10
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R10
    rx_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(rx_word));

    // R8
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == pol_lvl));

    // R7
    clkonly_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conly_lvl) |-> !sdo);

    // R3
    sdo_idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(sdo)) |-> (sclk == pol_lvl));

    // R1
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(pol_lvl));

endmodule

bind sync_shift_master ssm_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .sclk      (sclk),
    .sdo       (sdo),
    .pol_lvl   (seq_pol),
    .conly_lvl (seq_conly),
    .rx_word   (rx_word)
);

// File: tb/tb_sync_shift_master.sv
module tb_sync_shift_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] tx_word = '0;
    logic [15:0] xfer_len = '0;
    logic [15:0] half_div = '0;
    logic        clk_only = 1'b0;
    logic        idle_high = 1'b0;
    logic        sdi = 1'b0;
    logic        sclk, sdo, busy, done;
    logic [15:0] rx_word;

    always #10 clk = ~clk;

    sync_shift_master dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
        .xfer_len(xfer_len), .half_div(half_div), .clk_only(clk_only),
        .idle_high(idle_high), .sdi(sdi), .sclk(sclk), .sdo(sdo),
        .busy(busy), .done(done), .rx_word(rx_word)
    );

    typedef struct {
        logic [15:0] rx;
        int          pulses;
        logic [15:0] sbits;
        int          gap;
        string       tag;
    } exp_t;

    exp_t        expq[$];
    int          checks = 0;
    int          fails = 0;
    int          sent = 0;
    int          got = 0;
    logic [31:0] cur_seed = '0;
    logic        cur_pol = 1'b0;
    bit          finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, expv);
        end
    endtask

    // Monitor: watches the serial pins and scores each finished transfer.
    int          pcount = 0, gap = 0, gmin = 0, gmax = 0;
    logic        prev_sclk = 1'b0, prev_busy = 1'b0;
    logic [15:0] sbits = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            pcount = 0; gap = 0; gmin = 0; gmax = 0; sbits = '0;
        end else begin
            if (sclk != prev_sclk && prev_busy) begin
                if (gmin == 0 || gap < gmin) gmin = gap;
                if (gap > gmax) gmax = gap;
                if (sclk != cur_pol) begin
                    if (pcount < 16) sbits[pcount] = sdo;
                    pcount++;
                end
                gap = 1;
            end else if (busy) begin
                gap++;
            end
            if (got != sent && done && expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                chk(rx_word == e.rx, e.tag, "rx_word", rx_word, e.rx);
                chk(pcount == e.pulses, "R1", "pulse count", pcount, e.pulses);
                chk(sbits == e.sbits, "R3", "sdo bits", sbits, e.sbits);
                chk(gmin == e.gap && gmax == e.gap, "R2", "level length",
                    (gmin == e.gap) ? gmax : gmin, e.gap);
                pcount = 0; gap = 0; gmin = 0; gmax = 0; sbits = '0;
                got++;
            end
        end
        prev_sclk = sclk;
        prev_busy = busy;
        sdi = cur_seed[pcount % 32];
    end

    // Driver: computes the expected result from the requirements and starts a transfer.
    task automatic run_xfer(input logic [15:0] tx, input logic [15:0] len,
                            input logic [15:0] h, input bit co, input bit pol,
                            input logic [31:0] seed, input string tag, input bit poke);
        exp_t        e;
        logic [15:0] sh;
        sh = tx;
        e.sbits = '0;
        for (int i = 0; i < int'(len); i++) begin
            if (i < 16) e.sbits[i] = co ? 1'b0 : sh[0];
            if (!co) sh = {seed[i % 32], sh[15:1]};
        end
        e.rx     = sh;
        e.pulses = int'(len);
        e.gap    = (len == 0) ? 0 : ((h == 0) ? 1 : int'(h));
        e.tag    = tag;
        @(negedge clk);
        tx_word = tx; xfer_len = len; half_div = h; clk_only = co; idle_high = pol;
        cur_seed = seed; cur_pol = pol;
        expq.push_back(e);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        sent++;
        if (poke) begin
            // R9: a second start with different settings during the transfer
            repeat (3) @(negedge clk);
            tx_word = ~tx; clk_only = ~co; idle_high = ~pol; xfer_len = 16'd3; half_div = 16'd1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            tx_word = tx; clk_only = co; idle_high = pol; xfer_len = len; half_div = h;
        end
        while (got != sent) @(negedge clk);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R10 watchdog: actual=0x0 expected=0x1 (transfer never completed)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 / R10: reset state
        chk(sclk == 1'b0, "R8", "reset sclk", sclk, 0);
        chk(busy == 1'b0, "R10", "reset busy", busy, 0);
        chk(done == 1'b0, "R10", "reset done", done, 0);
        chk(sdo == 1'b0, "R3", "reset sdo", sdo, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_xfer(16'hA5C3, 16'd0,  16'd3, 1'b0, 1'b0, 32'h0,        "R1", 1'b0);
        run_xfer(16'h12F0, 16'd8,  16'd2, 1'b0, 1'b0, 32'h0000_00B6, "R4", 1'b0);
        run_xfer(16'hC3A5, 16'd16, 16'd1, 1'b0, 1'b0, 32'h0000_5E17, "R5", 1'b0);
        run_xfer(16'h0F0F, 16'd5,  16'd0, 1'b0, 1'b0, 32'h0000_0013, "R2", 1'b0);
        run_xfer(16'hBEEF, 16'd20, 16'd3, 1'b0, 1'b0, 32'h000A_93C4, "R6", 1'b0);
        run_xfer(16'h7E81, 16'd37, 16'd2, 1'b1, 1'b1, 32'hFFFF_FFFF, "R7", 1'b0);
        // R8: clock back at the latched high idle level
        repeat (2) @(negedge clk);
        chk(sclk == 1'b1, "R8", "idle high sclk", sclk, 1);
        run_xfer(16'h5A3C, 16'd12, 16'd4, 1'b0, 1'b1, 32'h0000_0A65, "R9", 1'b1);

        // R10: done held while idle
        repeat (10) @(negedge clk);
        chk(done == 1'b1, "R10", "done held", done, 1);
        chk(busy == 1'b0, "R10", "busy after done", busy, 0);

        run_xfer(16'h9669, 16'hFFFF, 16'd0, 1'b1, 1'b0, 32'h1234_5678, "R7", 1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule